// File: doc/BRIEF.md
# Memory-Mapped Console Register Interface

This block lets a processor talk to a simple console through four word registers in its address space. A keyboard-side receiver latches each incoming character and raises a ready flag. Software polls the flag, or takes an interrupt, and then reads the character. A display-side transmitter accepts a character through a data-register store, sends it to the display, and reports busy until the display signals completion.

The processor side is a single-cycle word bus. Read data is a combinational function of the address and the current register state. Side effects such as clear-on-read and send-on-write take place at the clock edge that ends the access. Each channel has a control register and a data register. In a control register, bit 0 is a hardware-owned ready flag and bit 1 is a software interrupt enable. One interrupt request output combines both channels.

Top module: `console_mmio`

## Requirements
- R1: After reset the receiver ready flag is 0, the transmitter ready flag is 1, both interrupt enables are 0, `irq` is 0 and `tx_valid` is 0.
- R2: Registers sit at `BASE`+0x0 (receiver control), +0x4 (receiver data), +0x8 (transmitter control) and +0xC (transmitter data). Any other address, including a non-word-aligned one, reads as zero, and a write to it changes nothing. A write to the receiver data register is ignored.
- R3: In both control registers, bit 0 reads the ready flag, bit 1 reads and writes the interrupt enable, and all other bits read 0. A write never changes the ready flag.
- R4: A cycle with `rx_valid` high stores `rx_char` and sets the receiver ready flag. A receiver data read returns the stored character in bits 7:0, with zeros above.
- R5: A read (`bus_re`) of the receiver data register clears the receiver ready flag at the end of that cycle. A read of either control register changes no flag.
- R6: A character that arrives while the receiver ready flag is 1 replaces the stored byte and leaves the flag at 1. When an arrival and a receiver data read fall in the same cycle, the read returns the old byte, the new byte is stored, and the flag stays 1.
- R7: A transmitter data write while the transmitter ready flag is 1 clears the flag. In the next cycle it gives a single-cycle `tx_valid` pulse with `tx_char` equal to write data bits 7:0.
- R8: A transmitter data write while the transmitter ready flag is 0 is ignored: there is no `tx_valid` pulse and `tx_char` keeps its value.
- R9: A `tx_done` pulse sets the transmitter ready flag. When `tx_done` and a transmitter data write fall in the same cycle while the flag is 0, the write is ignored and the flag becomes 1.
- R10: `irq` is high exactly when (receiver ready and receiver enable) or (transmitter ready and transmitter enable).
- R11: The transmitter data register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (32) | Byte address of the access |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_re | input | 1 | Read strobe for this cycle (enables read side effects) |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for the addressed register, same cycle |
| rx_valid | input | 1 | Keyboard side: character strobe |
| rx_char | input | CHAR_W (8) | Keyboard side: character |
| tx_valid | output | 1 | Display side: single-cycle send strobe |
| tx_char | output | CHAR_W (8) | Display side: character being sent |
| tx_done | input | 1 | Display side: previous character finished |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can fall in the same cycle. On the receiver side, a new character can arrive in the same cycle that software reads the data register. On the transmitter side, the display's done pulse can coincide with a store to the data register while the channel is busy. The bench provokes both by driving the device strobe and the bus access on the same falling edge. For the receiver it judges that the read returns the old byte and that the flag stays set with the new byte stored. For the transmitter it judges that no send strobe follows and that the ready flag reads 1 afterwards.

// File: rtl/console_pkg.sv
package console_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RX_CTRL,
        SEL_RX_DATA,
        SEL_TX_CTRL,
        SEL_TX_DATA
    } reg_sel_e;

    localparam int RDY_BIT = 0;
    localparam int IE_BIT  = 1;

    localparam logic [3:0] OFF_RX_CTRL = 4'h0;
    localparam logic [3:0] OFF_RX_DATA = 4'h4;
    localparam logic [3:0] OFF_TX_CTRL = 4'h8;
    localparam logic [3:0] OFF_TX_DATA = 4'hC;

endpackage

// File: rtl/console_addr_dec.sv
module console_addr_dec
    import console_pkg::*;
#(
    parameter int                ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE   = 32'hFFFF_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int OFF_W = 4;

    logic in_window;

    always_comb begin
        in_window = (addr[ADDR_W-1:OFF_W] == BASE[ADDR_W-1:OFF_W]);
        sel       = SEL_NONE;
        if (in_window) begin
            unique case (addr[OFF_W-1:0])
                OFF_RX_CTRL: sel = SEL_RX_CTRL;
                OFF_RX_DATA: sel = SEL_RX_DATA;
                OFF_TX_CTRL: sel = SEL_TX_CTRL;
                OFF_TX_DATA: sel = SEL_TX_DATA;
                default:     sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/console_rx_chan.sv
module console_rx_chan #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              ie_wdata,
    input  logic              data_rd,
    input  logic              char_valid,
    input  logic [CHAR_W-1:0] char_in,
    output logic              ready,
    output logic              ie,
    output logic [CHAR_W-1:0] held_char
);
    typedef struct packed {
        logic              ready;
        logic              ie;
        logic [CHAR_W-1:0] data;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            st_d.ie = ie_wdata;
        end
        if (data_rd) begin
            st_d.ready = 1'b0;
        end
        if (char_valid) begin
            st_d.ready = 1'b1;
            st_d.data  = char_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready     = st_q.ready;
    assign ie        = st_q.ie;
    assign held_char = st_q.data;
endmodule

// File: rtl/console_tx_chan.sv
module console_tx_chan #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              ie_wdata,
    input  logic              data_wr,
    input  logic [CHAR_W-1:0] wchar,
    input  logic              done,
    output logic              ready,
    output logic              ie,
    output logic              send_valid,
    output logic [CHAR_W-1:0] send_char
);
    typedef struct packed {
        logic              ready;
        logic              ie;
        logic              pulse;
        logic [CHAR_W-1:0] data;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (ctrl_wr) begin
            st_d.ie = ie_wdata;
        end
        if (done) begin
            st_d.ready = 1'b1;
        end
        if (data_wr && st_q.ready) begin
            st_d.ready = 1'b0;
            st_d.pulse = 1'b1;
            st_d.data  = wchar;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.ready <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready      = st_q.ready;
    assign ie         = st_q.ie;
    assign send_valid = st_q.pulse;
    assign send_char  = st_q.data;
endmodule

// File: rtl/console_mmio.sv
module console_mmio
    import console_pkg::*;
#(
    parameter int                ADDR_W = 32,
    parameter int                DATA_W = 32,
    parameter int                CHAR_W = 8,
    parameter logic [ADDR_W-1:0] BASE   = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_char,
    input  logic              tx_done,
    output logic              irq
);
    localparam int CTRL_PAD = DATA_W - 2;
    localparam int CHAR_PAD = DATA_W - CHAR_W;

    reg_sel_e          sel;
    logic              rx_ready, rx_ie, tx_ready, tx_ie;
    logic [CHAR_W-1:0] rx_held;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CHAR_W];

    console_addr_dec #(.ADDR_W(ADDR_W), .BASE(BASE)) dec_i (
        .addr (bus_addr),
        .sel  (sel)
    );

    console_rx_chan #(.CHAR_W(CHAR_W)) rx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (bus_we && (sel == SEL_RX_CTRL)),
        .ie_wdata   (bus_wdata[IE_BIT]),
        .data_rd    (bus_re && (sel == SEL_RX_DATA)),
        .char_valid (rx_valid),
        .char_in    (rx_char),
        .ready      (rx_ready),
        .ie         (rx_ie),
        .held_char  (rx_held)
    );

    console_tx_chan #(.CHAR_W(CHAR_W)) tx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (bus_we && (sel == SEL_TX_CTRL)),
        .ie_wdata   (bus_wdata[IE_BIT]),
        .data_wr    (bus_we && (sel == SEL_TX_DATA)),
        .wchar      (bus_wdata[CHAR_W-1:0]),
        .done       (tx_done),
        .ready      (tx_ready),
        .ie         (tx_ie),
        .send_valid (tx_valid),
        .send_char  (tx_char)
    );

    always_comb begin
        unique case (sel)
            SEL_RX_CTRL: bus_rdata = {{CTRL_PAD{1'b0}}, rx_ie, rx_ready};
            SEL_RX_DATA: bus_rdata = {{CHAR_PAD{1'b0}}, rx_held};
            SEL_TX_CTRL: bus_rdata = {{CTRL_PAD{1'b0}}, tx_ie, tx_ready};
            default:     bus_rdata = '0;
        endcase
    end

    assign irq = (rx_ready && rx_ie) || (tx_ready && tx_ie);
endmodule

// File: rtl/console_mmio_chk.sv
module console_mmio_chk #(
    parameter int                ADDR_W = 32,
    parameter int                CHAR_W = 8,
    parameter logic [ADDR_W-1:0] BASE   = 32'hFFFF_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_re,
    input logic [CHAR_W-1:0] wchar,
    input logic              rx_valid,
    input logic              tx_done,
    input logic              tx_valid,
    input logic [CHAR_W-1:0] tx_char,
    input logic              rx_ready,
    input logic              tx_ready
);
    localparam logic [ADDR_W-1:0] A_RXC = BASE + ADDR_W'(32'h0);
    localparam logic [ADDR_W-1:0] A_RXD = BASE + ADDR_W'(32'h4);
    localparam logic [ADDR_W-1:0] A_TXD = BASE + ADDR_W'(32'hC);

    // R4: an arrival always leaves the receiver flag set
    assert_rx_arrival_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> rx_ready);

    // R5: a data read with no arrival clears the flag
    assert_rx_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == A_RXD && !rx_valid) |=> !rx_ready);

    // R3: control write leaves the ready flag alone
    assert_ctrl_keeps_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_RXC && !rx_valid) |=> $stable(rx_ready));

    // R7: accepted write produces a send strobe with the written byte
    assert_tx_send_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_TXD && tx_ready) |=>
            (tx_valid && !tx_ready && tx_char == $past(wchar)));

    // R7: the send strobe lasts one cycle
    assert_tx_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid);

    // R8: a send strobe only follows an accepted write
    assert_tx_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_we && bus_addr == A_TXD && tx_ready)) |=> !tx_valid);

    // R9: done while busy restores readiness
    assert_tx_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !tx_ready) |=> tx_ready);
endmodule

bind console_mmio console_mmio_chk #(
    .ADDR_W (ADDR_W),
    .CHAR_W (CHAR_W),
    .BASE   (BASE)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_re   (bus_re),
    .wchar    (bus_wdata[CHAR_W-1:0]),
    .rx_valid (rx_valid),
    .tx_done  (tx_done),
    .tx_valid (tx_valid),
    .tx_char  (tx_char),
    .rx_ready (rx_ready),
    .tx_ready (tx_ready)
);

// File: tb/console_mmio_tb.sv
`timescale 1ns/1ps
module console_mmio_tb_top;

    localparam logic [31:0] BASE = 32'hFFFF_0000;
    localparam logic [3:0] OP_IDLE = 4'd0;
    localparam logic [3:0] OP_WR   = 4'd1;
    localparam logic [3:0] OP_RD   = 4'd2;
    localparam logic [3:0] OP_RX   = 4'd3;
    localparam logic [3:0] OP_IRQ  = 4'd4;
    localparam int NV = 33;

    // {op, requirement, offset, data, expected}
    localparam logic [79:0] VEC [NV] = '{
        {OP_RD,  4'd1,  8'h00, 32'h0,        32'h0},   // R1 rx flag clear
        {OP_RD,  4'd1,  8'h08, 32'h0,        32'h1},   // R1 tx ready
        {OP_RX,  4'd4,  8'h00, 32'h41,       32'h0},
        {OP_RD,  4'd4,  8'h00, 32'h0,        32'h1},   // R4 flag set
        {OP_RD,  4'd5,  8'h00, 32'h0,        32'h1},   // R5 ctrl read no clear
        {OP_RD,  4'd4,  8'h04, 32'h0,        32'h41},  // R4 byte
        {OP_RD,  4'd5,  8'h00, 32'h0,        32'h0},   // R5 cleared
        {OP_RX,  4'd6,  8'h00, 32'h42,       32'h0},
        {OP_RX,  4'd6,  8'h00, 32'h43,       32'h0},
        {OP_RD,  4'd6,  8'h00, 32'h0,        32'h1},   // R6 still set
        {OP_RD,  4'd6,  8'h04, 32'h0,        32'h43},  // R6 overwritten
        {OP_WR,  4'd3,  8'h00, 32'hFFFFFFFF, 32'h0},
        {OP_RD,  4'd3,  8'h00, 32'h0,        32'h2},   // R3 ie only
        {OP_IRQ, 4'd10, 8'h00, 32'h0,        32'h0},   // R10
        {OP_RX,  4'd10, 8'h00, 32'h10,       32'h0},
        {OP_IRQ, 4'd10, 8'h00, 32'h0,        32'h1},   // R10 rx
        {OP_RD,  4'd5,  8'h04, 32'h0,        32'h10},
        {OP_IRQ, 4'd10, 8'h00, 32'h0,        32'h0},   // R10 dropped
        {OP_WR,  4'd3,  8'h00, 32'h0,        32'h0},
        {OP_RD,  4'd3,  8'h00, 32'h0,        32'h0},   // R3
        {OP_WR,  4'd3,  8'h08, 32'h2,        32'h0},
        {OP_RD,  4'd3,  8'h08, 32'h0,        32'h3},   // R3 tx ie
        {OP_IRQ, 4'd10, 8'h00, 32'h0,        32'h1},   // R10 tx
        {OP_WR,  4'd3,  8'h08, 32'h0,        32'h0},
        {OP_RD,  4'd3,  8'h08, 32'h0,        32'h1},   // R3 ready kept
        {OP_RD,  4'd11, 8'h0C, 32'h0,        32'h0},   // R11
        {OP_WR,  4'd2,  8'h10, 32'hFFFF,     32'h0},
        {OP_RD,  4'd2,  8'h10, 32'h0,        32'h0},   // R2 unmapped
        {OP_RD,  4'd2,  8'h00, 32'h0,        32'h0},   // R2 no effect
        {OP_RD,  4'd2,  8'h08, 32'h0,        32'h1},   // R2 no effect
        {OP_WR,  4'd2,  8'h04, 32'h55,       32'h0},
        {OP_RD,  4'd2,  8'h04, 32'h0,        32'h10},  // R2 rx data write ignored
        {OP_RD,  4'd2,  8'h06, 32'h0,        32'h0}    // R2 unaligned
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_char = '0;
    logic        tx_valid;
    logic [7:0]  tx_char;
    logic        tx_done = 1'b0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    console_mmio dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rx_valid  (rx_valid),
        .rx_char   (rx_char),
        .tx_valid  (tx_valid),
        .tx_char   (tx_char),
        .tx_done   (tx_done),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [7:0] off,
                         input logic [31:0] d, input logic done);
        @(negedge clk);
        bus_we    = (op == OP_WR);
        bus_re    = (op == OP_RD);
        bus_addr  = BASE + {24'h0, off};
        bus_wdata = d;
        rx_valid  = (op == OP_RX);
        rx_char   = d[7:0];
        tx_done   = done;
        #1;
    endtask

    task automatic idle();
        apply(OP_IDLE, 8'h10, 32'h0, 1'b0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                fails++;
                checks++;
                $display("FAIL watchdog cycles actual=%0d expected<=5000", cycles);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [79:0] v;
            string tag;
            v = VEC[i];
            apply(v[79:76], v[71:64], v[63:32], 1'b0);
            tag = $sformatf("R%0d vec%0d", v[75:72], i);
            if (v[79:76] == OP_RD)  check(tag, bus_rdata, v[31:0]);
            if (v[79:76] == OP_IRQ) check(tag, {31'h0, irq}, v[31:0]);
        end

        // R7: accepted send
        apply(OP_WR, 8'h0C, 32'h1F7, 1'b0);
        idle();
        check("R7 tx_valid", {31'h0, tx_valid}, 32'h1);
        check("R7 tx_char", {24'h0, tx_char}, 32'hF7);
        apply(OP_RD, 8'h08, 32'h0, 1'b0);
        check("R7 ready cleared", bus_rdata, 32'h0);
        check("R7 single pulse", {31'h0, tx_valid}, 32'h0);

        // R8: write while busy ignored
        apply(OP_WR, 8'h0C, 32'h99, 1'b0);
        idle();
        check("R8 no pulse", {31'h0, tx_valid}, 32'h0);
        check("R8 char kept", {24'h0, tx_char}, 32'hF7);

        // R9: done and write in the same cycle while busy
        apply(OP_WR, 8'h0C, 32'h66, 1'b1);
        apply(OP_RD, 8'h08, 32'h0, 1'b0);
        check("R9 no pulse", {31'h0, tx_valid}, 32'h0);
        check("R9 ready set", bus_rdata, 32'h1);
        apply(OP_WR, 8'h0C, 32'h66, 1'b0);
        idle();
        check("R9 later send", {23'h0, tx_valid, tx_char}, 32'h166);
        apply(OP_IDLE, 8'h10, 32'h0, 1'b1);
        apply(OP_RD, 8'h08, 32'h0, 1'b0);
        check("R9 done", bus_rdata, 32'h1);

        // R6: arrival in the same cycle as a data read
        apply(OP_RX, 8'h00, 32'h70, 1'b0);
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b1; bus_addr = BASE + 32'h4;
        rx_valid = 1'b1; rx_char = 8'h71; tx_done = 1'b0;
        #1;
        check("R6 old byte read", bus_rdata, 32'h70);
        apply(OP_RD, 8'h00, 32'h0, 1'b0);
        check("R6 flag kept", bus_rdata, 32'h1);
        apply(OP_RD, 8'h04, 32'h0, 1'b0);
        check("R6 new byte", bus_rdata, 32'h71);
        apply(OP_RD, 8'h00, 32'h0, 1'b0);
        check("R6 cleared after", bus_rdata, 32'h0);

        // R1: reset in mid-run
        apply(OP_WR, 8'h08, 32'h2, 1'b0);
        apply(OP_RX, 8'h00, 32'h33, 1'b0);
        apply(OP_WR, 8'h0C, 32'h44, 1'b0);
        rst_n = 1'b0;
        idle();
        check("R1 reset irq", {31'h0, irq}, 32'h0);
        check("R1 reset tx_valid", {31'h0, tx_valid}, 32'h0);
        rst_n = 1'b1;
        apply(OP_RD, 8'h00, 32'h0, 1'b0);
        check("R1 reset rx ctrl", bus_rdata, 32'h0);
        apply(OP_RD, 8'h08, 32'h0, 1'b0);
        check("R1 reset tx ctrl", bus_rdata, 32'h1);
        apply(OP_RD, 8'h04, 32'h0, 1'b0);
        check("R1 reset rx data", bus_rdata, 32'h0);
        idle();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule